// File: doc/BRIEF.md
# Tape Controller Command and Status Register Interface

This block is the programmed-I/O face of a block-addressed tape controller. It holds a 12-bit command register and a status register, and it decodes six I/O transfer instructions that the host issues on two device select codes. The command register selects the transport unit, direction, stop/go, mode, function and interrupt enable. The status register carries five sticky error flags, a 3-bit memory field and the done flag. The host reads both registers by OR-ing them onto its accumulator, and it loads them through the same instructions.

The rest of the controller sends single-cycle set pulses for the mark-track, end-of-tape, parity and timing errors and for completion. The block sets the select error itself whenever the command register holds the reserved function code. It also forms a summary error flag and an interrupt request. Accumulator OR-in data, the accumulator-clear strobe and the skip strobe are combinational during the instruction cycle. Register updates take effect at the clock edge that ends that cycle.

Top module: `tape_ctl_regs`

## Requirements
- R1: An instruction takes effect only in a cycle with `iot_valid_i` high, `iot_dev_i` equal to octal 76 or 77, and `iot_op_i` equal to 1, 2 or 4. Any other device code or op value leaves the outputs at zero and the registers unchanged.
- R2: Load-A (device 76, op 4) replaces command bits 0–9 by their exclusive-OR with accumulator bits 0–9 and asserts `ac_clr_o`. Accumulator bit k is `ac_i[11-k]`, so bit 0 is the MSB, and command bit k is read back on `ac_or_o[11-k]`.
- R3: During Load-A, accumulator bit 10 at 0 clears all five error flags and accumulator bit 11 at 0 clears the done flag. A value of 1 in either bit leaves that flag unchanged.
- R4: Read-A (device 76, op 1) drives the command register onto `ac_or_o`. Its fields are: bits 0–2 unit (000 is unit 0), bit 3 reverse, bit 4 go, bit 5 continuous mode, bits 6–8 function, bit 9 interrupt enable, and bits 10–11 always zero. The same fields appear on the decoded outputs.
- R5: Clear-A (device 76, op 2) zeroes the command register and leaves the error, done and memory-field state unchanged.
- R6: Skip (device 77, op 1) asserts `skip_o` when the summary error flag or the done flag is set.
- R7: Read-B (device 77, op 2) drives status onto `ac_or_o` with this layout: bit 0 summary error, bit 1 mark-track, bit 2 end-of-tape, bit 3 select, bit 4 parity, bit 5 timing, bits 6–8 memory field, bits 9–10 zero, bit 11 done.
- R8: Load-B (device 77, op 4) loads the memory field from accumulator bits 6–8, asserts `ac_clr_o`, and leaves the error flags unchanged.
- R9: While the command function field (bits 6–8) holds 111, the select error is set at each clock edge. It is visible from the second edge after the Load-A that produced the code.
- R10: `err_flag_o` is the OR of the five error flags. `irq_o` is (done AND interrupt enable) OR `err_flag_o`.
- R11: A set pulse from the controller wins over a clear requested in the same cycle.
- R12: After reset, the command register, all flags and the memory field are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| iot_valid_i | input | 1 | Instruction cycle strobe |
| iot_dev_i | input | 6 | Device select code |
| iot_op_i | input | 3 | Operation pulse code (1, 2 or 4) |
| ac_i | input | 12 | Accumulator contents, bit 0 at index 11 |
| ac_or_o | output | 12 | Data OR-ed into the accumulator |
| ac_clr_o | output | 1 | Clear-accumulator strobe |
| skip_o | output | 1 | Skip-next-instruction strobe |
| set_mark_err_i | input | 1 | Set mark-track error |
| set_end_err_i | input | 1 | Set end-of-tape error |
| set_par_err_i | input | 1 | Set parity error |
| set_tim_err_i | input | 1 | Set timing error |
| set_done_i | input | 1 | Set done flag |
| unit_o | output | 3 | Selected transport unit |
| reverse_o | output | 1 | Direction, 1 = reverse |
| go_o | output | 1 | Motion, 1 = go |
| cont_mode_o | output | 1 | 1 = continuous mode |
| func_o | output | 3 | Function code |
| mem_field_o | output | 3 | Memory field |
| err_flag_o | output | 1 | Summary error flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the collisions: a set pulse arriving in the same cycle as a Load-A that clears that flag, and the select error reappearing after a clear because the reserved function code is still held. The bench drives a controller set pulse and an accumulator clear bit in the same instruction cycle. It then reads status back with Read-B to check that the new flag survived and the old ones did not. It also toggles the function field to 111 and issues Load-B afterwards to confirm that the memory-field load leaves the select error in place.

// File: rtl/tape_ctl_pkg.sv
package tape_ctl_pkg;
  localparam int unsigned WORD_W  = 12;
  localparam int unsigned DEV_W   = 6;
  localparam int unsigned OP_W    = 3;
  localparam int unsigned FIELD_W = 3;
  localparam int unsigned N_ERR   = 5;
  localparam int unsigned LOAD_W  = 10; // bits 0..9 loadable

  localparam logic [OP_W-1:0] OP_P1 = 3'd1;
  localparam logic [OP_W-1:0] OP_P2 = 3'd2;
  localparam logic [OP_W-1:0] OP_P4 = 3'd4;

  localparam logic [FIELD_W-1:0] FUNC_RESV = 3'b111;

  // error flag vector order, MSB first: mark, end, select, parity, timing
  localparam int unsigned ERR_SEL = 2;

  typedef struct packed {
    logic rd_a;
    logic clr_a;
    logic ld_a;
    logic skp;
    logic rd_b;
    logic ld_b;
  } iot_strb_t;
endpackage

// File: rtl/tc_iot_decode.sv
module tc_iot_decode
  import tape_ctl_pkg::*;
#(
  parameter logic [DEV_W-1:0] DEV_CMD = 6'o76,
  parameter logic [DEV_W-1:0] DEV_STS = 6'o77
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic [OP_W-1:0]  op_i,
  output iot_strb_t        strb_o
);
  logic hit_cmd, hit_sts;

  assign hit_cmd = valid_i && (dev_i == DEV_CMD);
  assign hit_sts = valid_i && (dev_i == DEV_STS);

  always_comb begin
    strb_o       = '0;
    strb_o.rd_a  = hit_cmd && (op_i == OP_P1);
    strb_o.clr_a = hit_cmd && (op_i == OP_P2);
    strb_o.ld_a  = hit_cmd && (op_i == OP_P4);
    strb_o.skp   = hit_sts && (op_i == OP_P1);
    strb_o.rd_b  = hit_sts && (op_i == OP_P2);
    strb_o.ld_b  = hit_sts && (op_i == OP_P4);
  end

  // R1
  strb_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strb_o));
  // R1
  no_strb_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (strb_o == '0));
endmodule

// File: rtl/tc_cmd_reg.sv
module tc_cmd_reg
  import tape_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ld_i,
  input  logic [WORD_W-1:0] ac_i,
  output logic [WORD_W-1:0] cmd_o
);
  localparam int unsigned FIX_W = WORD_W - LOAD_W;

  logic [LOAD_W-1:0] cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_q <= '0;
    else if (clr_i)  cmd_q <= '0;
    else if (ld_i)   cmd_q <= cmd_q ^ ac_i[WORD_W-1 -: LOAD_W];
  end

  assign cmd_o = {cmd_q, {FIX_W{1'b0}}};

  // R5
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cmd_o == '0));
  // R2
  ld_xor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !clr_i) |=> (cmd_o[WORD_W-1 -: LOAD_W] ==
                          $past(cmd_o[WORD_W-1 -: LOAD_W] ^ ac_i[WORD_W-1 -: LOAD_W])));
  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !clr_i) |=> $stable(cmd_o));
endmodule

// File: rtl/tc_status_reg.sv
module tc_status_reg
  import tape_ctl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_ERR-1:0]   err_set_i,
  input  logic               err_clr_i,
  input  logic               done_set_i,
  input  logic               done_clr_i,
  input  logic               mf_ld_i,
  input  logic [FIELD_W-1:0] mf_i,
  output logic [N_ERR-1:0]   err_o,
  output logic               done_o,
  output logic [FIELD_W-1:0] mf_o
);
  logic [FIELD_W-1:0] mf_q;
  logic               done_q;

  for (genvar g = 0; g < N_ERR; g++) begin : g_err
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           flag_q <= 1'b0;
      else if (err_set_i[g]) flag_q <= 1'b1; // set beats clear
      else if (err_clr_i)    flag_q <= 1'b0;
    end
    assign err_o[g] = flag_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         done_q <= 1'b0;
    else if (done_set_i) done_q <= 1'b1;
    else if (done_clr_i) done_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mf_q <= '0;
    else if (mf_ld_i) mf_q <= mf_i;
  end

  assign done_o = done_q;
  assign mf_o   = mf_q;

  // R11
  done_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_set_i |=> done_o);
  // R11
  err_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_set_i != '0) |=> ((err_o & $past(err_set_i)) == $past(err_set_i)));
  // R3
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && (err_set_i == '0)) |=> (err_o == '0));
  // R8
  mf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mf_ld_i |=> $stable(mf_o));
endmodule

// File: rtl/tape_ctl_regs.sv
module tape_ctl_regs
  import tape_ctl_pkg::*;
#(
  parameter logic [DEV_W-1:0] DEV_CMD = 6'o76,
  parameter logic [DEV_W-1:0] DEV_STS = 6'o77
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               iot_valid_i,
  input  logic [DEV_W-1:0]   iot_dev_i,
  input  logic [OP_W-1:0]    iot_op_i,
  input  logic [WORD_W-1:0]  ac_i,
  output logic [WORD_W-1:0]  ac_or_o,
  output logic               ac_clr_o,
  output logic               skip_o,
  input  logic               set_mark_err_i,
  input  logic               set_end_err_i,
  input  logic               set_par_err_i,
  input  logic               set_tim_err_i,
  input  logic               set_done_i,
  output logic [FIELD_W-1:0] unit_o,
  output logic               reverse_o,
  output logic               go_o,
  output logic               cont_mode_o,
  output logic [FIELD_W-1:0] func_o,
  output logic [FIELD_W-1:0] mem_field_o,
  output logic               err_flag_o,
  output logic               irq_o
);
  localparam int unsigned MSB = WORD_W - 1;

  iot_strb_t          strb;
  logic [WORD_W-1:0]  cmd;
  logic [N_ERR-1:0]   err, err_set;
  logic               done, int_en, sel_set;
  logic [WORD_W-1:0]  sts_word;

  tc_iot_decode #(.DEV_CMD(DEV_CMD), .DEV_STS(DEV_STS)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (iot_valid_i),
    .dev_i   (iot_dev_i),
    .op_i    (iot_op_i),
    .strb_o  (strb)
  );

  tc_cmd_reg u_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (strb.clr_a),
    .ld_i   (strb.ld_a),
    .ac_i   (ac_i),
    .cmd_o  (cmd)
  );

  // accumulator bit k sits at index MSB-k
  assign unit_o      = cmd[MSB -: FIELD_W];
  assign reverse_o   = cmd[MSB-3];
  assign go_o        = cmd[MSB-4];
  assign cont_mode_o = cmd[MSB-5];
  assign func_o      = cmd[MSB-6 -: FIELD_W];
  assign int_en      = cmd[MSB-9];

  assign sel_set = (func_o == FUNC_RESV);
  assign err_set = {set_mark_err_i, set_end_err_i, sel_set, set_par_err_i, set_tim_err_i};

  tc_status_reg u_sts (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .err_set_i  (err_set),
    .err_clr_i  (strb.ld_a && !ac_i[MSB-10]),
    .done_set_i (set_done_i),
    .done_clr_i (strb.ld_a && !ac_i[MSB-11]),
    .mf_ld_i    (strb.ld_b),
    .mf_i       (ac_i[MSB-6 -: FIELD_W]),
    .err_o      (err),
    .done_o     (done),
    .mf_o       (mem_field_o)
  );

  assign err_flag_o = |err;
  assign irq_o      = (done && int_en) || err_flag_o;

  assign sts_word = {err_flag_o, err, mem_field_o, 2'b00, done};

  always_comb begin
    ac_or_o = '0;
    if (strb.rd_a) ac_or_o = cmd;
    if (strb.rd_b) ac_or_o = sts_word;
  end

  assign ac_clr_o = strb.ld_a || strb.ld_b;
  assign skip_o   = strb.skp && (err_flag_o || done);

  // R9
  sel_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_o == FUNC_RESV) |=> err[ERR_SEL]);
  // R5
  clr_a_keeps_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb.clr_a |=> ((err & ~$past(err)) == ($past(err_set) & ~$past(err))));
  // R10
  irq_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_flag_o |-> irq_o);
  // R6
  skip_only_on_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> (err_flag_o || done));
endmodule

// File: tb/tape_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module tape_ctl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iot_valid = 1'b0;
  logic [5:0]  iot_dev = '0;
  logic [2:0]  iot_op = '0;
  logic [11:0] ac = '0;
  logic [11:0] ac_or;
  logic        ac_clr, skip;
  logic        s_mark = 1'b0, s_end = 1'b0, s_par = 1'b0, s_tim = 1'b0, s_done = 1'b0;
  logic [2:0]  unit, func, mf;
  logic        rev, go, cont, errf, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tape_ctl_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .iot_valid_i(iot_valid), .iot_dev_i(iot_dev),
    .iot_op_i(iot_op), .ac_i(ac), .ac_or_o(ac_or), .ac_clr_o(ac_clr), .skip_o(skip),
    .set_mark_err_i(s_mark), .set_end_err_i(s_end), .set_par_err_i(s_par),
    .set_tim_err_i(s_tim), .set_done_i(s_done), .unit_o(unit), .reverse_o(rev),
    .go_o(go), .cont_mode_o(cont), .func_o(func), .mem_field_o(mf),
    .err_flag_o(errf), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%o expected=%o", req, act, exp);
    end
  endtask

  logic [11:0] c_or;
  logic        c_clr, c_skip;

  // drive one instruction: outputs captured mid-cycle, state updates at the edge
  task automatic iot(input logic [5:0] dev, input logic [2:0] op, input logic [11:0] a);
    @(negedge clk);
    iot_valid = 1'b1; iot_dev = dev; iot_op = op; ac = a;
    #1;
    c_or = ac_or; c_clr = ac_clr; c_skip = skip;
    @(negedge clk);
    iot_valid = 1'b0; iot_dev = '0; iot_op = '0; ac = '0;
  endtask

  // {dev, op, ac, exp_or, exp_clr, exp_skip}
  localparam int NV = 11;
  localparam logic [34:0] VEC [NV] = '{
    {6'o76, 3'd4, 12'o5217, 12'o0000, 1'b1, 1'b0}, // R2 load A
    {6'o76, 3'd1, 12'o0000, 12'o5214, 1'b0, 1'b0}, // R4 read A
    {6'o77, 3'd1, 12'o0000, 12'o0000, 1'b0, 1'b0}, // R6 no flags, no skip
    {6'o77, 3'd4, 12'o0050, 12'o0000, 1'b1, 1'b0}, // R8 load B mf=5
    {6'o77, 3'd2, 12'o0000, 12'o0050, 1'b0, 1'b0}, // R7 read B
    {6'o76, 3'd4, 12'o0013, 12'o0000, 1'b1, 1'b0}, // R2 toggle func bit 8
    {6'o76, 3'd1, 12'o0000, 12'o5204, 1'b0, 1'b0}, // R4
    {6'o75, 3'd1, 12'o0000, 12'o0000, 1'b0, 1'b0}, // R1 foreign device
    {6'o76, 3'd2, 12'o0000, 12'o0000, 1'b0, 1'b0}, // R5 clear A
    {6'o76, 3'd1, 12'o0000, 12'o0000, 1'b0, 1'b0}, // R5 read back zero
    {6'o77, 3'd2, 12'o0000, 12'o0050, 1'b0, 1'b0}  // R5 mf kept
  };

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: s_par = 1'b1;
      1: s_done = 1'b1;
      default: s_mark = 1'b1;
    endcase
    @(negedge clk);
    s_par = 1'b0; s_done = 1'b0; s_mark = 1'b0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 unit", {9'd0, unit}, 12'd0);
    chk("R12 flags", {9'd0, errf, irq, skip}, 12'd0);
    chk("R12 mf", {9'd0, mf}, 12'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      iot(VEC[i][34:29], VEC[i][28:26], VEC[i][25:14]);
      chk($sformatf("vec%0d or", i), c_or, VEC[i][13:2]);
      chk($sformatf("vec%0d clr/skip", i), {10'd0, c_clr, c_skip}, {10'd0, VEC[i][1:0]});
    end

    // R1 op value 3 on command device ignored
    iot(6'o76, 3'd3, 12'o7777);
    iot(6'o76, 3'd1, 12'o0000);
    chk("R1 bad op ignored", c_or, 12'o0000);

    // R4 field outputs: unit 5, reverse, go, cont, func 6
    iot(6'o76, 3'd4, 12'o5763);
    chk("R4 fields", {unit, rev, go, cont, func, 3'b000}, 12'o5760);
    iot(6'o76, 3'd2, 12'o0000);

    // R6 R10 done flag, irq gated by enable
    pulse(1);
    iot(6'o77, 3'd1, 12'o0000);
    chk("R6 skip on done", {11'd0, c_skip}, 12'd1);
    chk("R10 irq without enable", {11'd0, irq}, 12'd0);
    iot(6'o76, 3'd4, 12'o0007);
    chk("R10 irq with enable", {11'd0, irq}, 12'd1);
    iot(6'o77, 3'd2, 12'o0000);
    chk("R7 done bit", c_or, 12'o0051);

    // R3 clear done only
    iot(6'o76, 3'd4, 12'o0002);
    iot(6'o77, 3'd2, 12'o0000);
    chk("R3 done cleared", c_or, 12'o0050);
    chk("R10 irq drops", {11'd0, irq}, 12'd0);

    // R10 parity error
    pulse(0);
    chk("R10 summary error", {10'd0, errf, irq}, 12'd3);
    iot(6'o77, 3'd2, 12'o0000);
    chk("R7 parity layout", c_or, 12'o4250);

    // R11 timing set with error clear in same cycle
    @(negedge clk);
    iot_valid = 1'b1; iot_dev = 6'o76; iot_op = 3'd4; ac = 12'o0001; s_tim = 1'b1;
    @(negedge clk);
    iot_valid = 1'b0; iot_dev = '0; iot_op = '0; ac = '0; s_tim = 1'b0;
    iot(6'o77, 3'd2, 12'o0000);
    chk("R11 set beats clear", c_or, 12'o4150);

    // R3 plain error clear, done untouched (done=0)
    iot(6'o76, 3'd4, 12'o0001);
    iot(6'o77, 3'd2, 12'o0000);
    chk("R3 errors cleared", c_or, 12'o0050);

    // R11 done set with done clear in same cycle
    @(negedge clk);
    iot_valid = 1'b1; iot_dev = 6'o76; iot_op = 3'd4; ac = 12'o0002; s_done = 1'b1;
    @(negedge clk);
    iot_valid = 1'b0; iot_dev = '0; iot_op = '0; ac = '0; s_done = 1'b0;
    iot(6'o77, 3'd1, 12'o0000);
    chk("R11 done kept", {11'd0, c_skip}, 12'd1);
    iot(6'o76, 3'd4, 12'o0002);

    // R9 reserved function
    iot(6'o76, 3'd4, 12'o0073);
    iot(6'o77, 3'd2, 12'o0000);
    chk("R9 select error", c_or, 12'o4450);
    iot(6'o76, 3'd4, 12'o0001);
    iot(6'o77, 3'd2, 12'o0000);
    chk("R9 held while code 111", c_or, 12'o4450);

    // R8 load B keeps errors
    iot(6'o77, 3'd4, 12'o0030);
    chk("R8 acc clear", {11'd0, c_clr}, 12'd1);
    iot(6'o77, 3'd2, 12'o0000);
    chk("R8 mf load keeps errors", c_or, 12'o4430);

    // R5 clear A keeps errors; select error then clearable
    iot(6'o76, 3'd2, 12'o0000);
    iot(6'o77, 3'd2, 12'o0000);
    chk("R5 flags kept", c_or, 12'o4430);
    iot(6'o76, 3'd4, 12'o0001);
    iot(6'o77, 3'd2, 12'o0000);
    chk("R9 clear after code leaves", c_or, 12'o0030);

    // R10 mark-track error alone
    pulse(2);
    iot(6'o77, 3'd2, 12'o0000);
    chk("R7 mark layout", c_or, 12'o6030);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule